// File: doc/BRIEF.md
# Multi-cycle integer multiply/divide unit

This unit executes the eight integer multiply, divide and remainder operations of the RV32M extension for a processor datapath that stalls while the unit works. The datapath presents two operands and a 3-bit operation code together with `start`. The unit accepts the request whenever it is idle, raises `busy` while it computes, and then raises `done` for one cycle with the 32-bit answer on `result`. The answer stays on `result` until the next answer replaces it.

Products come out of a two-stage pipelined multiplier, so every multiply takes the same short time. Quotients and remainders come out of a restoring divider that works on operand magnitudes and yields one quotient bit per clock. The signs are applied to the result afterwards. Division by zero and the signed overflow case never trap: they are answered at once with the values the instruction set defines.

Top module: `mdu_top`

## Requirements
- R1: The operation code follows the funct3 order (0 mul, 1 mulh, 2 mulhsu, 3 mulhu, 4 div, 5 divu, 6 rem, 7 remu). `op`, `opa` and `opb` are captured on the rising edge where `start` is high and `busy` is low. Later changes to these inputs do not affect that result.
- R2: mul returns the low 32 bits of the product.
- R3: mulh, mulhsu and mulhu return the high 32 bits of the 64-bit product. mulh treats both operands as signed. mulhsu treats `opa` as signed and `opb` as unsigned. mulhu treats both as unsigned.
- R4: A multiply shows `done` exactly 2 clock cycles after its accepting edge, with `busy` high in between.
- R5: div and rem truncate toward zero. The remainder carries the sign of the dividend. divu and remu treat both operands as unsigned.
- R6: A divide or remainder with a nonzero divisor and no signed overflow shows `done` exactly 33 cycles after its accepting edge, with `busy` high in between.
- R7: With `opb` equal to zero, div and divu return 0xFFFFFFFF and rem and remu return `opa`. `done` is raised in the cycle right after the accepting edge, and `busy` never rises.
- R8: Signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 for div and 0 for rem. It completes as fast as R7.
- R9: `done` lasts one cycle per result, and `busy` is low in every cycle where `done` is high. A `start` raised while `busy` is high is ignored.
- R10: A new request raised in the cycle where `done` is high is accepted on the next edge and handled correctly.
- R11: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when `busy` is low |
| op | input | 3 | Operation code, funct3 order |
| opa | input | 32 | First operand (multiplicand or dividend) |
| opb | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 32 | Registered result |

## Verification
The bench builds the unit with the default word width of 32. At that width the 33-cycle divide latency is checked exactly, and the overflow value 0x80000000 with divisor 0xFFFFFFFF can be driven directly. The high-half products of the extreme operands can also be compared against 64-bit bench arithmetic. Random operands are biased toward zero, all ones, the most negative value and small numbers, so the zero-divisor and overflow shortcuts come up often. Requests are issued back to back, and the bench changes the inputs after each accepting edge, which exercises operand capture and acceptance in the `done` cycle on every operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdu_op_e;
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] out_res
);
  localparam int PW = 2 * W;

  logic          v1, v2, hi1, hi2;
  logic [PW-1:0] a_w, b_w, prod;
  logic          a_sgn, b_sgn;

  // mulh (01) and mulhsu (10) treat a as signed; only mulh treats b as signed
  assign a_sgn = (kind == 2'd1) || (kind == 2'd2);
  assign b_sgn = (kind == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    a_w  <= {{W{a_sgn & a[W-1]}}, a};
    b_w  <= {{W{b_sgn & b[W-1]}}, b};
    hi1  <= (kind != 2'd0);
    prod <= a_w * b_w;
    hi2  <= hi1;
  end

  assign out_valid = v2;
  assign out_res   = hi2 ? prod[PW-1:W] : prod[W-1:0];

  a_r4_pipe_advance: assert property (@(posedge clk) disable iff (rst) v1 |=> v2);
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem_r, quo_r, dvs_r;
  logic [W:0]    shifted, diff;
  logic          ge;

  assign shifted = {rem_r, quo_r[W-1]};
  assign diff    = shifted - {1'b0, dvs_r};
  assign ge      = ~diff[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      rem_r  <= '0;
      quo_r  <= '0;
      dvs_r  <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= CW'(W);
      rem_r  <= '0;
      quo_r  <= dvd;
      dvs_r  <= dvs;
    end else if (active) begin
      if (cnt != '0) begin
        cnt   <= cnt - CW'(1);
        rem_r <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo_r <= {quo_r[W-2:0], ge};
      end else begin
        active <= 1'b0;
      end
    end
  end

  assign fin = active && (cnt == '0);
  assign quo = quo_r;
  assign rem = rem_r;

  a_r6_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0) |=> active);
  a_r9_no_reload: assert property (@(posedge clk) disable iff (rst) !(load && active));
endmodule

// File: rtl/mdu_top.sv
module mdu_top #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  import mdu_pkg::*;

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  mdu_op_e      op_e;
  logic         accept, is_div, sdiv, want_rem, b_zero, ovf, special;
  logic         a_neg, b_neg, mul_go, div_go;
  logic [W-1:0] a_mag, b_mag, spec_val, div_val;
  logic         mul_v, div_fin;
  logic [W-1:0] mul_res, quo, rem;
  logic         neg_q_r, neg_r_r, rem_sel_r;

  assign op_e     = mdu_op_e'(op);
  assign accept   = start && !busy;
  assign is_div   = op[2];
  assign sdiv     = (op_e == OP_DIV) || (op_e == OP_REM);
  assign want_rem = (op_e == OP_REM) || (op_e == OP_REMU);
  assign b_zero   = (opb == '0);
  assign ovf      = sdiv && (opa == MINV) && (opb == '1);
  assign special  = is_div && (b_zero || ovf);
  assign spec_val = b_zero ? (want_rem ? opa : '1) : (want_rem ? '0 : MINV);

  assign a_neg = sdiv && opa[W-1];
  assign b_neg = sdiv && opb[W-1];
  assign a_mag = a_neg ? -opa : opa;
  assign b_mag = b_neg ? -opb : opb;

  assign mul_go = accept && !is_div;
  assign div_go = accept && is_div && !special;

  mdu_mul #(.W(W)) i_mul (
    .clk(clk), .rst(rst), .in_valid(mul_go), .kind(op[1:0]),
    .a(opa), .b(opb), .out_valid(mul_v), .out_res(mul_res)
  );

  mdu_div #(.W(W)) i_div (
    .clk(clk), .rst(rst), .load(div_go), .dvd(a_mag), .dvs(b_mag),
    .fin(div_fin), .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q_r   <= 1'b0;
      neg_r_r   <= 1'b0;
      rem_sel_r <= 1'b0;
    end else if (div_go) begin
      neg_q_r   <= a_neg ^ b_neg;
      neg_r_r   <= a_neg;
      rem_sel_r <= want_rem;
    end
  end

  assign div_val = rem_sel_r ? (neg_r_r ? -rem : rem) : (neg_q_r ? -quo : quo);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= (accept && special) || mul_v || div_fin;
      if (accept && special) result <= spec_val;
      else if (mul_v)        result <= mul_res;
      else if (div_fin)      result <= div_val;
      if (mul_v || div_fin)       busy <= 1'b0;
      else if (mul_go || div_go)  busy <= 1'b1;
    end
  end

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  a_r4_mul_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !op[2]) |=> busy);
  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op[2] && opb == '0) |=> (done && !busy));
  a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 3'd4 && opa == MINV && opb == '1) |=> (done && result == MINV));
endmodule

// File: tb/test_mdu_top.sv
`timescale 1ns/1ps
module test_mdu_top;
  logic        clk = 1'b0;
  logic        rst, start;
  logic [2:0]  op;
  logic [31:0] opa, opb;
  logic        busy, done;
  logic [31:0] result;
  int          checks = 0;
  int          errs = 0;
  localparam logic [31:0] MINV = 32'h8000_0000;

  always #2.5 clk = ~clk;

  mdu_top #(.W(32)) i_mdu_top (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_res(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    int sa, sb;
    sa = a; sb = b;
    case (o)
      3'd0: begin p = a * b; return p[31:0]; end
      3'd1: begin p = {{32{a[31]}}, a} * {{32{b[31]}}, b}; return p[63:32]; end
      3'd2: begin p = {{32{a[31]}}, a} * {32'd0, b}; return p[63:32]; end
      3'd3: begin p = {32'd0, a} * {32'd0, b}; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == MINV && b == 32'hFFFF_FFFF) return MINV;
        return 32'(sa / sb);
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (a == MINV && b == 32'hFFFF_FFFF) return 32'd0;
        return 32'(sa % sb);
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic int ref_lat(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    if (!o[2]) return 2;
    if (b == 0) return 0;
    if (!o[0] && a == MINV && b == 32'hFFFF_FFFF) return 0;
    return 33;
  endfunction

  function automatic string res_tag(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    if (o == 3'd0) return "R2";
    if (!o[2]) return "R3";
    if (b == 0) return "R7";
    if (!o[0] && a == MINV && b == 32'hFFFF_FFFF) return "R8";
    return "R5";
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, input string rt);
    int k, lat;
    logic [31:0] ex;
    string lt, tg;
    while (busy) @(negedge clk);
    ex  = ref_res(o, a, b);
    lat = ref_lat(o, a, b);
    lt  = (lat == 2) ? "R4" : ((lat == 0) ? "R7" : "R6");
    tg  = (rt == "") ? res_tag(o, a, b) : rt;
    start = 1'b1; op = o; opa = a; opb = b;
    @(posedge clk); @(negedge clk);
    // R1: scramble the inputs after the accepting edge
    start = 1'b0; op = 3'($urandom); opa = $urandom; opb = $urandom;
    k = 0;
    while (!done && k < 40) begin
      chk(busy, lt, 32'(busy), 32'd1);
      if (poke && k == 3) start = 1'b1;   // R9: request while busy
      else start = 1'b0;
      @(posedge clk); @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == lat, lt, 32'(k), 32'(lat));
    chk(result == ex, poke ? "R9" : tg, result, ex);
    chk(!busy, "R9", 32'(busy), 32'd0);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'd0;
      1: return MINV;
      2: return 32'hFFFF_FFFF;
      3: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; op = '0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && result == 0, "R11", {busy, done, result[29:0]}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    run_op(3'd0, 32'd7, 32'hFFFF_FFFD, 1'b0, "");
    run_op(3'd1, MINV, MINV, 1'b0, "");
    run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "");
    run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "");
    run_op(3'd4, 32'hFFFF_FFF9, 32'd2, 1'b0, "");
    run_op(3'd6, 32'hFFFF_FFF9, 32'd2, 1'b0, "");
    run_op(3'd5, 32'hFFFF_FFF9, 32'd2, 1'b0, "");
    run_op(3'd7, 32'hFFFF_FFF9, 32'd2, 1'b0, "");
    for (int i = 4; i < 8; i++) run_op(3'(i), 32'h1234_5678, 32'd0, 1'b0, "");
    run_op(3'd4, MINV, 32'hFFFF_FFFF, 1'b0, "");
    run_op(3'd6, MINV, 32'hFFFF_FFFF, 1'b0, "");
    run_op(3'd4, 32'd100, 32'd7, 1'b1, "");
    // R10: the multiply is raised in the done cycle of the divide
    run_op(3'd6, 32'd1000, 32'hFFFF_FFF3, 1'b0, "");
    run_op(3'd1, 32'h7FFF_FFFF, MINV, 1'b0, "R10");
    @(posedge clk); @(negedge clk);
    chk(!done, "R9", 32'(done), 32'd0);

    for (int i = 0; i < 200; i++) run_op(3'($urandom), pick(), pick(), 1'b0, "");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule